// File: doc/BRIEF.md
# Post-MSB Bit Tap and Word Delay

This block sits on a serial audio link that carries one word per frame, MSB first, clocked by a bit clock and framed by a word latch strobe. In each word it picks out the level of the bit that follows the MSB, which is the second-most-significant bit of a 16-bit sample. It holds that level for a whole word and then presents it on a single registered output one word later. The output then lines up with the next word that is being shifted into a converter. An external add/subtract stage reads the output: high means the error correction for that bit weight is applied, and low means no correction current flows.

The nominal frame has 24 bit clocks per latch period (4.2336 MHz against 176.4 kHz). A bit counter restarts on every latch. A small sequencer has three states. `ST_IDLE` waits for the first latch after reset. `ST_SEEK` counts toward the tap position. `ST_HELD` keeps the captured bit until the next latch. The transitions are as follows:
- IDLE→SEEK on a latch.
- SEEK→HELD when the counter reaches the tap position without a latch.
- SEEK→SEEK when a latch restarts a word that was cut short.
- HELD→SEEK on a latch.
- Any state→IDLE on reset.

Top module: `pmx_post_msb_tap`

## Requirements
- R1: A synchronous reset, `rst` high at a clock edge, drives `comp_en` to 0 at that edge and puts the sequencer in ST_IDLE.
- R2: Bit 0 of a word is the `ser_data` value sampled on the edge where `word_latch` is sampled high. Bit 1 is the value sampled on the next edge. On the edge where the next word's latch is sampled, `comp_en` takes the bit 1 value of the previous word.
- R3: `comp_en` changes only on an edge where `word_latch` is sampled high. It holds its value through every other cycle of the word.
- R4: Data bits other than bit 1 have no effect on `comp_en`. This covers the MSB, bits 2 to 15, and any padding bits up to the frame end.
- R5: If a word ends, by a new latch, before its bit 1 was sampled (a one-cycle word, or back-to-back latch cycles), `comp_en` is 0 after the following latch.
- R6: The first latch after reset loads 0 into `comp_en`.
- R7: Frames of any length from 2 bit clocks upward are accepted, including lengths beyond the nominal 24. The bit counter saturates instead of wrapping, so a long frame never causes a second capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit clock; all logic is on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_data | input | 1 | Serial audio data, MSB first |
| word_latch | input | 1 | Word latch strobe, high for the first bit of each word |
| comp_en | output | 1 | Delayed post-MSB bit; high enables the correction stage |

## Verification
The assertions assume that `word_latch` is sampled synchronously to `clk_bit` and that each high cycle marks bit 0 of a new word. They also assume that `ser_data` settles before the sampling edge. The stimulus meets these assumptions by changing both inputs only on the falling edge. Word lengths range from one cycle (consecutive latch cycles) through the nominal 24 to frames long enough to saturate the counter. Padding bits and the bits around bit 1 are randomized, so the stimulus keeps within what the assertions assume while still probing R4 and R7.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEEK = 2'd1,
        ST_HELD = 2'd2
    } pmx_state_t;
endpackage

// File: rtl/pmx_bit_counter.sv
module pmx_bit_counter #(
    parameter int CNT_W = 6,
    parameter int SAT   = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(SAT);

    // the count is the index of the next bit to arrive; bit 0 is taken on the latch edge
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (restart)
            cnt <= CNT_W'(1);
        else if (cnt != CNT_SAT)
            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/pmx_seq_fsm.sv
module pmx_seq_fsm
    import pmx_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int TAP_IDX = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             latch,
    input  logic [CNT_W-1:0] cnt,
    input  logic             sdata,
    output pmx_state_t       state,
    output logic             cap
);
    localparam logic [CNT_W-1:0] TAP_CNT = CNT_W'(TAP_IDX);

    pmx_state_t nxt;
    logic       at_tap;

    assign at_tap = (cnt == TAP_CNT) && !latch;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (latch)  nxt = ST_SEEK;
            ST_SEEK: if (latch)  nxt = ST_SEEK;
                     else if (at_tap) nxt = ST_HELD;
            ST_HELD: if (latch)  nxt = ST_SEEK;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // capture register: cleared at each word start, loaded at the tap position
    always_ff @(posedge clk) begin
        if (rst)
            cap <= 1'b0;
        else if (latch)
            cap <= 1'b0;
        else if (state == ST_SEEK && at_tap)
            cap <= sdata;
    end
endmodule

// File: rtl/pmx_out_hold.sv
module pmx_out_hold (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic din,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (load)
            q <= din;
    end
endmodule

// File: rtl/pmx_post_msb_tap.sv
module pmx_post_msb_tap
    import pmx_pkg::*;
#(
    parameter int MAX_FRAME_BITS = 32,
    parameter int TAP_IDX        = 1
) (
    input  logic clk_bit,
    input  logic rst,
    input  logic ser_data,
    input  logic word_latch,
    output logic comp_en
);
    localparam int CNT_W = $clog2(MAX_FRAME_BITS + 1);

    logic [CNT_W-1:0] bit_cnt;
    pmx_state_t       seq_state;
    logic             cap_bit;

    pmx_bit_counter #(.CNT_W(CNT_W), .SAT(MAX_FRAME_BITS)) u_cnt (
        .clk     (clk_bit),
        .rst     (rst),
        .restart (word_latch),
        .cnt     (bit_cnt)
    );

    pmx_seq_fsm #(.CNT_W(CNT_W), .TAP_IDX(TAP_IDX)) u_seq (
        .clk   (clk_bit),
        .rst   (rst),
        .latch (word_latch),
        .cnt   (bit_cnt),
        .sdata (ser_data),
        .state (seq_state),
        .cap   (cap_bit)
    );

    pmx_out_hold u_hold (
        .clk  (clk_bit),
        .rst  (rst),
        .load (word_latch),
        .din  (cap_bit),
        .q    (comp_en)
    );
endmodule

// File: rtl/pmx_checker.sv
module pmx_checker
    import pmx_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int TAP_IDX = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             latch,
    input logic [CNT_W-1:0] cnt,
    input pmx_state_t       state,
    input logic             comp
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!comp && state == ST_IDLE));  // R1

    AST_CAPTURE_STEP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEEK && !latch && cnt == CNT_W'(TAP_IDX)) |=> state == ST_HELD);  // R2

    AST_HOLD_BETWEEN_LATCHES: assert property (@(posedge clk) disable iff (rst)
        !latch |=> $stable(comp));  // R3

    AST_SHORT_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (latch && state == ST_SEEK) |=> !comp);  // R5

    AST_FIRST_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (latch && state == ST_IDLE) |=> !comp);  // R6

    AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        latch |=> cnt == CNT_W'(1));  // R7
endmodule

bind pmx_post_msb_tap pmx_checker #(.CNT_W(CNT_W), .TAP_IDX(TAP_IDX)) u_chk (
    .clk   (clk_bit),
    .rst   (rst),
    .latch (word_latch),
    .cnt   (bit_cnt),
    .state (seq_state),
    .comp  (comp_en)
);

// File: tb/tb_pmx_post_msb_tap.sv
module tb_pmx_post_msb_tap;
    logic clk_bit = 1'b0;
    logic rst = 1'b1;
    logic ser_data = 1'b0;
    logic word_latch = 1'b0;
    logic comp_en;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    bit pending = 1'b0;
    bit exp_q[$];
    string tag_q[$];
    string cur_tag = "R2";
    bit last_out = 1'b0;

    pmx_post_msb_tap dut (
        .clk_bit    (clk_bit),
        .rst        (rst),
        .ser_data   (ser_data),
        .word_latch (word_latch),
        .comp_en    (comp_en)
    );

    always #2.5 clk_bit = ~clk_bit;

    task automatic check(input string req, input bit act, input bit exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s comp_en=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // driver: one word of len cycles; bit 1 becomes the value for the next latch
    task automatic send_word(input logic [15:0] w, input int len, input string tag);
        exp_q.push_back(pending);
        tag_q.push_back(tag);
        for (int i = 0; i < len; i++) begin
            @(negedge clk_bit);
            word_latch = (i == 0);
            ser_data   = (i < 16) ? w[15-i] : 1'($urandom);
        end
        pending = (len >= 2) ? w[14] : 1'b0;
    endtask

    // monitor: compares after each sampled latch, checks stability otherwise (R3)
    initial begin
        forever begin
            bit l_q, r_q;
            @(posedge clk_bit);
            l_q = word_latch;
            r_q = rst;
            @(negedge clk_bit);
            if (!r_q) begin
                if (l_q) begin
                    if (exp_q.size() == 0) check("R2 underflow", comp_en, ~comp_en);
                    else check(tag_q.pop_front(), comp_en, exp_q.pop_front());
                end else begin
                    check("R3", comp_en, last_out);
                end
            end
            last_out = comp_en;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_bit);
        check("R1", comp_en, 1'b0);
        @(negedge clk_bit);
        rst = 1'b0;
        // R6: first latch after reset loads 0 even with bit 1 high
        send_word(16'h4000, 24, "R6");
        send_word(16'h0000, 24, "R2");        // expects 1 from previous
        send_word(16'hBFFF, 24, "R2");        // expects 0; all bits but bit 1 high (R4)
        send_word(16'h4000, 24, "R4");        // expects 0 despite busy word before
        send_word(16'hC000, 24, "R4");        // expects 1
        send_word(16'h7FFF, 2, "R7");         // minimal frame, expects 1
        send_word(16'h0000, 40, "R7");        // long saturating frame, expects 1 (bit 1 of 7FFF)
        send_word(16'hFFFF, 1, "R7");         // expects 0
        send_word(16'hFFFF, 1, "R5");         // previous word cut short: expects 0
        send_word(16'hFFFF, 24, "R5");        // previous cut short: expects 0
        send_word(16'h0000, 24, "R2");        // expects 1
        for (int k = 0; k < 200; k++)
            send_word(16'($urandom), 2 + ($urandom % 38), "R2");
        send_word(16'h0000, 24, "R2");
        // reset mid-stream, then first word again zero
        @(negedge clk_bit);
        rst = 1'b1;
        word_latch = 1'b0;
        @(negedge clk_bit);
        @(negedge clk_bit);
        check("R1", comp_en, 1'b0);
        exp_q.delete();
        tag_q.delete();
        rst = 1'b0;
        pending = 1'b0;
        send_word(16'h4000, 24, "R6");
        send_word(16'h0000, 24, "R2");
        @(negedge clk_bit);
        word_latch = 1'b0;
        repeat (3) @(negedge clk_bit);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule